// File: doc/BRIEF.md
# Status Register Field-Masked Write Unit

This block keeps the processor's current status word and one saved copy of it for each of the five exception modes that have one. Software can write the current word or the saved copy of the current mode one byte field at a time. A four-bit field mask picks which bytes change. The ALU can refresh the four condition flags. Exception entry takes a snapshot of the current word into the saved copy of the mode being entered. Exception return brings the saved copy back into the current word.

The current mode lives in bits [2:0] of the current word. All mode-dependent behaviour keys off that field. This covers the protection that lets an unprivileged program touch only the flags field, and the choice of which saved copy is visible. Every update takes effect on the clock edge that samples the strobes. The saved copy of the current mode is presented combinationally from the stored state.

Top module: `psr_status_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the current word becomes 32'h0000_0003 (supervisor mode, every other bit zero) and all five saved copies become zero.
- R2: With `wr_en`=1 and `wr_saved`=0, each byte of the current word whose mask bit is set takes the matching byte of `wr_data` on the next edge: mask bit 0 selects [7:0] (control), bit 1 selects [15:8] (extension), bit 2 selects [23:16] (status), bit 3 selects [31:24] (flags). Bytes whose mask bit is clear keep their value.
- R3: With `alu_upd`=1, bits [31:28] of the current word take `alu_nzcv` (bit 3 = N at bit 31, bit 2 = Z at bit 30, bit 1 = C at bit 29, bit 0 = V at bit 28). All other bits keep their value.
- R4: When an ALU update and a current-word write with mask bit 3 set happen in the same cycle, the flags byte takes `wr_data[31:24]`. If mask bit 3 is clear, the ALU value is applied.
- R5: In user mode (mode field 3'b000), a current-word write changes only the flags byte. Mask bits 0 to 2 are ignored.
- R6: Mode codes are 000 user, 001 fast interrupt, 010 interrupt, 011 supervisor, 100 abort, 101 undefined, 111 system. Modes 001 to 101 own saved slots 0 to 4. Modes 000, 110 and 111 own no saved copy, and an exception entry that targets one of them is ignored.
- R7: On `exc_enter` with `exc_mode` in 001 to 101, the saved copy of that mode takes the whole current word, and the current word's mode field becomes `exc_mode` while bits [31:3] are kept.
- R8: On `exc_return` while the current mode owns a saved copy, the current word is replaced by that saved copy. In other modes the return is ignored.
- R9: `saved_psr` shows the saved copy of the current mode, and shows zero when the current mode owns none.
- R10: With `wr_en`=1 and `wr_saved`=1, the saved copy of the current mode is written under the same byte mask as R2, with no user-mode restriction. In a mode without a saved copy the write has no effect.
- R11: An accepted entry overrides return, writes and ALU updates in that cycle. An accepted return overrides writes and ALU updates. An ignored entry or return does not block the lower-priority actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Status write strobe |
| wr_saved | input | 1 | Write target: 0 current word, 1 saved copy of current mode |
| wr_mask | input | 4 | Byte field mask (bit0 control … bit3 flags) |
| wr_data | input | 32 | Write data |
| alu_upd | input | 1 | Condition flag update strobe |
| alu_nzcv | input | 4 | New N, Z, C, V flags |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| exc_mode | input | 3 | Mode being entered |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved copy of the current mode, zero if none |

## Verification
A wrong byte merge or a wrong priority appears on `cur_psr` one edge after the faulty cycle. A wrong slot during a save stays hidden until that mode becomes current again. It then appears on `saved_psr` right after entry, or in `cur_psr` one edge after return. For this reason the stimulus enters, writes and returns through every mode many times, so that a corrupted slot is read back soon after the fault. A leak of a saved copy into user or system mode appears at once as a nonzero `saved_psr`.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W      = 32;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = PSR_W / BYTE_W;
    localparam int NUM_SAVED  = 5;
    localparam int MODE_W     = 3;
    localparam int NZCV_W     = 4;
    localparam int FLAG_LSB   = PSR_W - NZCV_W;
    localparam int FLAG_FIELD = NUM_FIELDS - 1;
    localparam int SLOT_W     = $clog2(NUM_SAVED);

    typedef enum logic [MODE_W-1:0] {
        MODE_USER = 3'd0,
        MODE_FIQ  = 3'd1,
        MODE_IRQ  = 3'd2,
        MODE_SVC  = 3'd3,
        MODE_ABT  = 3'd4,
        MODE_UND  = 3'd5,
        MODE_RSV  = 3'd6,
        MODE_SYS  = 3'd7
    } mode_e;

    localparam logic [PSR_W-1:0] PSR_RESET = {{(PSR_W-MODE_W){1'b0}}, MODE_SVC};

    typedef struct packed {
        logic              en;
        logic [SLOT_W-1:0] slot;
        logic [PSR_W-1:0]  value;
    } bank_load_t;

    function automatic logic has_saved(input logic [MODE_W-1:0] m);
        return (m >= MODE_FIQ) && (m <= MODE_UND);
    endfunction

    function automatic logic [SLOT_W-1:0] slot_of(input logic [MODE_W-1:0] m);
        logic [MODE_W-1:0] s;
        s = m - MODE_W'(1);
        return s[SLOT_W-1:0];
    endfunction

    function automatic logic [NUM_FIELDS-1:0] allowed_fields(input logic [MODE_W-1:0] m,
                                                             input logic [NUM_FIELDS-1:0] mask);
        logic [NUM_FIELDS-1:0] only_flags;
        only_flags = '0;
        only_flags[FLAG_FIELD] = 1'b1;
        return (m == MODE_USER) ? (mask & only_flags) : mask;
    endfunction
endpackage

// File: rtl/psr_field_merge.sv
module psr_field_merge #(
    parameter int W  = 32,
    parameter int NF = 4
) (
    input  logic [W-1:0]  old_value,
    input  logic [W-1:0]  new_value,
    input  logic [NF-1:0] field_sel,
    output logic [W-1:0]  merged
);
    localparam int FW = W / NF;

    for (genvar f = 0; f < NF; f++) begin : g_field
        assign merged[f*FW +: FW] = field_sel[f] ? new_value[f*FW +: FW]
                                                  : old_value[f*FW +: FW];
    end
endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
    import psr_pkg::*;
#(
    parameter int N = NUM_SAVED
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_load_t        load,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [PSR_W-1:0]  rd_value
);
    logic [PSR_W-1:0] slot_q [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (load.en && (load.slot == SLOT_W'(i))) begin
                slot_q[i] <= load.value;
            end
        end
    end

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_slot == SLOT_W'(i)) rd_value = slot_q[i];
        end
    end
endmodule

// File: rtl/psr_current_reg.sv
module psr_current_reg
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PSR_W-1:0] next_value,
    output logic [PSR_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) value <= PSR_RESET;
        else     value <= next_value;
    end
endmodule

// File: rtl/psr_status_unit.sv
module psr_status_unit
    import psr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_saved,
    input  logic [3:0]  wr_mask,
    input  logic [31:0] wr_data,
    input  logic        alu_upd,
    input  logic [3:0]  alu_nzcv,
    input  logic        exc_enter,
    input  logic        exc_return,
    input  logic [2:0]  exc_mode,
    output logic [31:0] cur_psr,
    output logic [31:0] saved_psr
);
    logic [MODE_W-1:0]     cur_mode;
    logic                  cur_has_saved;
    logic                  enter_ok;
    logic                  return_ok;
    logic [PSR_W-1:0]      saved_raw;
    logic [PSR_W-1:0]      after_alu;
    logic [NUM_FIELDS-1:0] cur_fields;
    logic [PSR_W-1:0]      after_write;
    logic [PSR_W-1:0]      saved_written;
    logic [PSR_W-1:0]      cur_next;
    bank_load_t            bank_load;

    assign cur_mode      = cur_psr[MODE_W-1:0];
    assign cur_has_saved = has_saved(cur_mode);
    assign enter_ok      = exc_enter && has_saved(exc_mode);
    assign return_ok     = exc_return && cur_has_saved && !enter_ok;

    assign saved_psr = cur_has_saved ? saved_raw : '0;

    // Flag refresh first, so that a masked flags write merged on top wins.
    assign after_alu  = alu_upd ? {alu_nzcv, cur_psr[FLAG_LSB-1:0]} : cur_psr;
    assign cur_fields = (wr_en && !wr_saved) ? allowed_fields(cur_mode, wr_mask) : '0;

    psr_field_merge #(.W(PSR_W), .NF(NUM_FIELDS)) i_cur_merge (
        .old_value (after_alu),
        .new_value (wr_data),
        .field_sel (cur_fields),
        .merged    (after_write)
    );

    psr_field_merge #(.W(PSR_W), .NF(NUM_FIELDS)) i_saved_merge (
        .old_value (saved_raw),
        .new_value (wr_data),
        .field_sel (wr_mask),
        .merged    (saved_written)
    );

    always_comb begin
        if (enter_ok)       cur_next = {cur_psr[PSR_W-1:MODE_W], exc_mode};
        else if (return_ok) cur_next = saved_raw;
        else                cur_next = after_write;
    end

    always_comb begin
        bank_load = '0;
        if (enter_ok) begin
            bank_load.en    = 1'b1;
            bank_load.slot  = slot_of(exc_mode);
            bank_load.value = cur_psr;
        end else if (!return_ok && wr_en && wr_saved && cur_has_saved) begin
            bank_load.en    = 1'b1;
            bank_load.slot  = slot_of(cur_mode);
            bank_load.value = saved_written;
        end
    end

    psr_current_reg i_cur (
        .clk        (clk),
        .rst        (rst),
        .next_value (cur_next),
        .value      (cur_psr)
    );

    psr_saved_bank #(.N(NUM_SAVED)) i_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (bank_load),
        .rd_slot  (slot_of(cur_mode)),
        .rd_value (saved_raw)
    );
endmodule

// File: rtl/psr_status_checker.sv
module psr_status_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        wr_saved,
    input logic [3:0]  wr_mask,
    input logic [31:0] wr_data,
    input logic        alu_upd,
    input logic [3:0]  alu_nzcv,
    input logic        exc_enter,
    input logic        exc_return,
    input logic [2:0]  exc_mode,
    input logic [31:0] cur_psr,
    input logic [31:0] saved_psr
);
    logic ent_valid;
    logic quiet;
    assign ent_valid = exc_enter && (exc_mode >= 3'd1) && (exc_mode <= 3'd5);
    assign quiet     = !exc_enter && !exc_return;

    // R1
    a_r1_reset_value: assert property (@(posedge clk) rst |=> cur_psr == 32'h0000_0003);

    // R7
    a_r7_entry_saves: assert property (@(posedge clk) disable iff (rst)
        ent_valid |=> (saved_psr == $past(cur_psr)) && (cur_psr[2:0] == $past(exc_mode)));

    // R8
    a_r8_return_restores: assert property (@(posedge clk) disable iff (rst)
        (exc_return && !exc_enter && cur_psr[2:0] >= 3'd1 && cur_psr[2:0] <= 3'd5)
        |=> cur_psr == $past(saved_psr));

    // R5
    a_r5_user_low_fields_kept: assert property (@(posedge clk) disable iff (rst)
        (quiet && cur_psr[2:0] == 3'd0) |=> cur_psr[23:0] == $past(cur_psr[23:0]));

    // R9
    a_r9_no_copy_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (cur_psr[2:0] == 3'd0 || cur_psr[2:0] >= 3'd6) |-> saved_psr == 32'h0);

    // R4
    a_r4_write_beats_alu: assert property (@(posedge clk) disable iff (rst)
        (quiet && alu_upd && wr_en && !wr_saved && wr_mask[3])
        |=> cur_psr[31:24] == $past(wr_data[31:24]));

    // R2
    a_r2_unmasked_ext_kept: assert property (@(posedge clk) disable iff (rst)
        (quiet && !(wr_en && !wr_saved && wr_mask[1])) |=> $stable(cur_psr[15:8]));
endmodule

bind psr_status_unit psr_status_checker i_psr_status_checker (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_saved   (wr_saved),
    .wr_mask    (wr_mask),
    .wr_data    (wr_data),
    .alu_upd    (alu_upd),
    .alu_nzcv   (alu_nzcv),
    .exc_enter  (exc_enter),
    .exc_return (exc_return),
    .exc_mode   (exc_mode),
    .cur_psr    (cur_psr),
    .saved_psr  (saved_psr)
);

// File: tb/test_psr_status_unit.sv
module test_psr_status_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_saved, alu_upd, exc_enter, exc_return;
    logic [3:0]  wr_mask, alu_nzcv;
    logic [31:0] wr_data;
    logic [2:0]  exc_mode;
    logic [31:0] cur_psr, saved_psr;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_cur;
    logic [31:0] m_saved [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_status_unit i_psr_status_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_saved(wr_saved), .wr_mask(wr_mask),
        .wr_data(wr_data), .alu_upd(alu_upd), .alu_nzcv(alu_nzcv),
        .exc_enter(exc_enter), .exc_return(exc_return), .exc_mode(exc_mode),
        .cur_psr(cur_psr), .saved_psr(saved_psr)
    );

    function automatic bit owns(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd5);
    endfunction

    function automatic logic [31:0] exp_saved_out();
        return owns(m_cur[2:0]) ? m_saved[m_cur[2:0] - 3'd1] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Model update computed from the requirements, then one clock, then compare.
    task automatic step(input string tag, input bit we, input bit ws, input logic [3:0] mk,
                        input logic [31:0] d, input bit au, input logic [3:0] nz,
                        input bit en, input bit rt, input logic [2:0] em);
        logic [2:0] md;
        bit eo, ro;
        wr_en = we; wr_saved = ws; wr_mask = mk; wr_data = d;
        alu_upd = au; alu_nzcv = nz; exc_enter = en; exc_return = rt; exc_mode = em;
        md = m_cur[2:0];
        eo = en && owns(em);
        ro = rt && owns(md) && !eo;
        if (eo) begin
            m_saved[em - 3'd1] = m_cur;
            m_cur[2:0] = em;
        end else if (ro) begin
            m_cur = m_saved[md - 3'd1];
        end else begin
            if (au) m_cur[31:28] = nz;
            if (we && !ws)
                for (int b = 0; b < 4; b++)
                    if (mk[b] && (md != 3'd0 || b == 3)) m_cur[b*8 +: 8] = d[b*8 +: 8];
            if (we && ws && owns(md))
                for (int b = 0; b < 4; b++)
                    if (mk[b]) m_saved[md - 3'd1][b*8 +: 8] = d[b*8 +: 8];
        end
        @(negedge clk);
        check(tag, cur_psr, m_cur);
        check("R9", saved_psr, exp_saved_out());
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 0; wr_saved = 0; wr_mask = 0; wr_data = 0;
        alu_upd = 0; alu_nzcv = 0; exc_enter = 0; exc_return = 0; exc_mode = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_cur = 32'h0000_0003;
        for (int i = 0; i < 5; i++) m_saved[i] = 32'h0;
        check("R1", cur_psr, 32'h0000_0003);
        check("R1", saved_psr, 32'h0);

        // R2: flags and control selected, middle bytes untouched
        step("R2", 1, 0, 4'b1001, 32'hAABB_CC03, 0, 4'h0, 0, 0, 3'd0);
        // R4: write to flags wins over ALU
        step("R4", 1, 0, 4'b1000, 32'h1100_0000, 1, 4'b0101, 0, 0, 3'd0);
        // R3 / R4: ALU applies when flags byte unselected
        step("R3", 1, 0, 4'b0100, 32'h0077_0000, 1, 4'b1010, 0, 0, 3'd0);
        step("R3", 0, 0, 4'b0000, 32'h0, 1, 4'b0110, 0, 0, 3'd0);
        // R7: enter interrupt mode
        step("R7", 0, 0, 4'b0000, 32'h0, 0, 4'h0, 1, 0, 3'd2);
        // R10: saved-copy write under mask
        step("R10", 1, 1, 4'b0100, 32'h0055_0000, 0, 4'h0, 0, 0, 3'd0);
        // R8: return restores saved copy (back to supervisor)
        step("R8", 0, 0, 4'b0000, 32'h0, 0, 4'h0, 0, 1, 3'd0);
        // R8: return from supervisor with zero copy lands in user mode
        step("R8", 0, 0, 4'b0000, 32'h0, 0, 4'h0, 0, 1, 3'd0);
        // R5: user write limited to flags
        step("R5", 1, 0, 4'b1111, 32'hFFFF_FFFF, 0, 4'h0, 0, 0, 3'd0);
        // R8: return in user mode ignored
        step("R8", 0, 0, 4'b0000, 32'h0, 0, 4'h0, 0, 1, 3'd0);
        // R10: saved write in user mode has no effect
        step("R10", 1, 1, 4'b1111, 32'h1234_5678, 0, 4'h0, 0, 0, 3'd0);
        // R6: entries to system, reserved and user modes ignored
        step("R6", 0, 0, 4'b0000, 32'h0, 0, 4'h0, 1, 0, 3'd7);
        step("R6", 0, 0, 4'b0000, 32'h0, 0, 4'h0, 1, 0, 3'd6);
        step("R6", 1, 0, 4'b1000, 32'h3300_0000, 0, 4'h0, 1, 0, 3'd0);
        // R11: accepted entry drops same-cycle write and ALU update
        step("R11", 1, 0, 4'b1111, 32'hDEAD_BEEF, 1, 4'hF, 1, 1, 3'd1);
        // R11: accepted return drops same-cycle saved write
        step("R11", 1, 1, 4'b1111, 32'hCAFE_F00D, 1, 4'h9, 0, 1, 3'd0);

        for (int n = 0; n < 3000; n++) begin
            int kind;
            kind = $urandom_range(0, 99);
            rv = $urandom;
            step("R2", kind < 45, ($urandom_range(0, 3) == 0), 4'($urandom), rv,
                 ($urandom_range(0, 1) == 1), 4'($urandom),
                 (kind >= 80 && kind < 92), (kind >= 92), 3'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule